// File: doc/BRIEF.md
# Memory Response Containment Stage

This stage sits between a coherent memory device's media pipeline and its link-facing response port. Each accepted request, read or write, produces exactly one registered response one cycle later. The response carries a poison bit, a metadata field and the read data. Writes that target a persistent range and are allowed to land produce a one-cycle commit strobe. Reads and writes to addresses that no decoder claims are completed without touching storage.

The stage keeps a sticky error-containment state, here called viral. When the feature is enabled, the state is entered on an internal uncorrected fatal error or on a viral indication arriving from the link. While the state is active, the stage changes its behaviour in four ways:
- it stops poisoning, to avoid error pollution;
- it forces metadata to No-op;
- it drops persistent writes, while still completing them;
- it blocks the shutdown state from becoming clean.

Only a conventional reset clears the state. A link-protocol reset and a function-level reset leave it unchanged.

Top module: `mem_contain`

## Requirements
- R1: Outside the viral state, a response to a decoded read whose `req_data_bad` is 1 has `rsp_poison`=1, and a decoded read with good data has `rsp_poison`=0.
- R2: A response to a request accepted while `viral_status` is 1 never has `rsp_poison` set.
- R3: Metadata No-op is encoding 0. A read response passes `rd_meta` through only when the read is decoded, not suspect and accepted outside the viral state. Every other response (suspect read, undecoded read, write, or any request accepted while viral) carries No-op.
- R4: A persistent decoded write accepted while viral pulses no `pcommit`, yet still gets its response.
- R5: Every request with `req_valid`=1 produces `rsp_valid`=1 on the next cycle, with the same `rsp_write` and `rsp_tag`.
- R6: A persistent write accepted in the same cycle that the viral trigger arrives still pulses `pcommit`.
- R7: With `viral_en`=1, `fatal_err` sets `viral_status` and `viral_out` from the next cycle on, and both remain set.
- R8: With `viral_en`=0, `fatal_err` and `viral_in` leave `viral_status` at 0, and only poisoning applies.
- R9: With `viral_en`=1, `viral_in` sets the same sticky state as `fatal_err`.
- R10: A reset request (`rst_req`=1) is decoded by `rst_kind`: 00 is conventional, 01 is link-protocol, 10 is function-level. Only 00 clears the viral state; 01 and 10 leave it set.
- R11: A shutdown request (`sd_req`) with `sd_to_clean`=1 is acknowledged next cycle. While viral it fails with `sd_err`=1 and leaves `sd_clean` at 0; otherwise it sets `sd_clean`. A request with `sd_to_clean`=0 clears `sd_clean`. `gpf_done` sets `sd_clean` only outside the viral state.
- R12: An undecoded read returns all-ones data with no poison. An undecoded write never pulses `pcommit`. Persistent decoded writes outside viral pulse `pcommit`; volatile writes never do. Write responses carry zero data.
- R13: A read with `req_data_bad`=1 does not enter the viral state, even with `viral_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low conventional reset (cold) |
| viral_en | input | 1 | Viral feature enable |
| fatal_err | input | 1 | Internal uncorrected fatal error pulse |
| viral_in | input | 1 | Viral indication received from the link |
| rst_req | input | 1 | Reset event strobe |
| rst_kind | input | 2 | Reset type: 00 conventional, 01 link-protocol, 10 function-level |
| req_valid | input | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_persist | input | 1 | Target lies in a persistent range |
| req_decoded | input | 1 | Address claimed by a decoder |
| req_data_bad | input | 1 | Read data known or suspected bad |
| req_meta_suspect | input | 1 | Read metadata suspect |
| req_tag | input | TW | Request tag |
| rd_data | input | DW | Read data from media |
| rd_meta | input | MW | Metadata from media |
| sd_req | input | 1 | Shutdown-state change request |
| sd_to_clean | input | 1 | 1 = request clean, 0 = request dirty |
| gpf_done | input | 1 | Global persistent flush finished |
| rsp_valid | output | 1 | Response valid |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_tag | output | TW | Response tag |
| rsp_data | output | DW | Response data |
| rsp_poison | output | 1 | Poison marker |
| rsp_meta | output | MW | Metadata field |
| pcommit | output | 1 | Persistent write commit strobe |
| viral_status | output | 1 | Sticky viral status |
| viral_out | output | 1 | Viral indication toward the host |
| sd_ack | output | 1 | Shutdown request completed |
| sd_err | output | 1 | Shutdown request failed with internal error |
| sd_clean | output | 1 | Shutdown state is clean |

## Verification
The bench hits the edge where a persistent write and a fatal error share a cycle. A design that samples the updated state would lose that commit, which R6 forbids. It enters viral with the enable clear, with a bad read alone, and with each non-conventional reset type. A design that gates the state wrongly, or clears it too eagerly, shows a wrong `viral_status` at once. Inside viral it checks that bad reads come back unpoisoned with No-op metadata, and that a dropped persistent write still produces a response. A design that keeps poisoning, leaks metadata, or stalls the host would fail on those points. The shutdown check covers both a clean request and a global flush while viral, followed by the same two after a conventional clear.

// File: rtl/mem_contain.sv
module mem_contain #(
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int MW = 2,
  parameter logic [MW-1:0] META_NOOP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viral_en,
  input  logic          fatal_err,
  input  logic          viral_in,
  input  logic          rst_req,
  input  logic [1:0]    rst_kind,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_persist,
  input  logic          req_decoded,
  input  logic          req_data_bad,
  input  logic          req_meta_suspect,
  input  logic [TW-1:0] req_tag,
  input  logic [DW-1:0] rd_data,
  input  logic [MW-1:0] rd_meta,
  input  logic          sd_req,
  input  logic          sd_to_clean,
  input  logic          gpf_done,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_poison,
  output logic [MW-1:0] rsp_meta,
  output logic          pcommit,
  output logic          viral_status,
  output logic          viral_out,
  output logic          sd_ack,
  output logic          sd_err,
  output logic          sd_clean
);

  localparam logic [1:0] RK_CONV = 2'b00;

  logic viral_q;
  logic conv_clr, viral_trig;
  logic rd_ok;

  assign conv_clr   = rst_req && (rst_kind == RK_CONV);
  assign viral_trig = viral_en && (fatal_err || viral_in);
  assign rd_ok      = !req_write && req_decoded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          viral_q <= 1'b0;
    else if (conv_clr)   viral_q <= 1'b0;
    else if (viral_trig) viral_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
      rsp_poison <= 1'b0;
      rsp_meta   <= META_NOOP;
      pcommit    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_write  <= req_valid && req_write;
      rsp_tag    <= req_valid ? req_tag : '0;
      rsp_poison <= req_valid && rd_ok && req_data_bad && !viral_q;
      rsp_meta   <= (req_valid && rd_ok && !req_meta_suspect && !viral_q) ? rd_meta : META_NOOP;
      pcommit    <= req_valid && req_write && req_persist && req_decoded && !viral_q;
      if (!req_valid || req_write) rsp_data <= '0;
      else if (req_decoded)        rsp_data <= rd_data;
      else                         rsp_data <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_ack   <= 1'b0;
      sd_err   <= 1'b0;
      sd_clean <= 1'b0;
    end else begin
      sd_ack <= sd_req;
      sd_err <= sd_req && sd_to_clean && viral_q;
      if (sd_req) begin
        if (!sd_to_clean)  sd_clean <= 1'b0;
        else if (!viral_q) sd_clean <= 1'b1;
      end else if (gpf_done && !viral_q) begin
        sd_clean <= 1'b1;
      end
    end
  end

  assign viral_status = viral_q;
  assign viral_out    = viral_q;

endmodule

// File: rtl/mem_contain_chk.sv
module mem_contain_chk #(
  parameter int MW = 2,
  parameter logic [MW-1:0] META_NOOP = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          viral_en,
  input logic          rst_req,
  input logic [1:0]    rst_kind,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          rsp_poison,
  input logic [MW-1:0] rsp_meta,
  input logic          pcommit,
  input logic          viral_status,
  input logic          sd_ack,
  input logic          sd_err
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R5

  AST_NO_POISON_VIRAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(viral_status) |-> !rsp_poison); // R2

  AST_META_NOOP_VIRAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(viral_status) |-> rsp_meta == META_NOOP); // R3

  AST_NO_COMMIT_VIRAL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(viral_status) |-> !pcommit); // R4

  AST_VIRAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viral_status && !(rst_req && rst_kind == 2'b00) |=> viral_status); // R7

  AST_NO_ENTRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !viral_en && !viral_status |=> !viral_status); // R8

  AST_SD_FAIL_ONLY_VIRAL: assert property (@(posedge clk) disable iff (!rst_n)
    sd_ack && sd_err |-> $past(viral_status)); // R11

endmodule

bind mem_contain mem_contain_chk #(.MW(MW), .META_NOOP(META_NOOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .viral_en(viral_en), .rst_req(rst_req),
  .rst_kind(rst_kind), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_poison(rsp_poison), .rsp_meta(rsp_meta), .pcommit(pcommit),
  .viral_status(viral_status), .sd_ack(sd_ack), .sd_err(sd_err)
);

// File: tb/mem_contain_tb.sv
module mem_contain_tb_top;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic viral_en = 0, fatal_err = 0, viral_in = 0, rst_req = 0;
  logic [1:0] rst_kind = '0;
  logic req_valid = 0, req_write = 0, req_persist = 0, req_decoded = 0;
  logic req_data_bad = 0, req_meta_suspect = 0;
  logic [TW-1:0] req_tag = '0;
  logic [DW-1:0] rd_data = '0;
  logic [MW-1:0] rd_meta = '0;
  logic sd_req = 0, sd_to_clean = 0, gpf_done = 0;
  logic rsp_valid, rsp_write, rsp_poison, pcommit, viral_status, viral_out;
  logic sd_ack, sd_err, sd_clean;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;
  logic [MW-1:0] rsp_meta;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mem_contain #(.DW(DW), .TW(TW), .MW(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .viral_en(viral_en), .fatal_err(fatal_err),
    .viral_in(viral_in), .rst_req(rst_req), .rst_kind(rst_kind),
    .req_valid(req_valid), .req_write(req_write), .req_persist(req_persist),
    .req_decoded(req_decoded), .req_data_bad(req_data_bad),
    .req_meta_suspect(req_meta_suspect), .req_tag(req_tag), .rd_data(rd_data),
    .rd_meta(rd_meta), .sd_req(sd_req), .sd_to_clean(sd_to_clean),
    .gpf_done(gpf_done), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rsp_poison(rsp_poison),
    .rsp_meta(rsp_meta), .pcommit(pcommit), .viral_status(viral_status),
    .viral_out(viral_out), .sd_ack(sd_ack), .sd_err(sd_err), .sd_clean(sd_clean)
  );

  // {wr, persist, decoded, bad, suspect, meta[1:0], exp_poison, exp_meta[1:0], exp_commit}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_1_0_0_10_0_10_0,  // R1 R3 good read, meta passes
    11'b0_0_1_1_0_11_1_11_0,  // R1 bad read poisoned
    11'b0_0_1_0_1_10_0_00_0,  // R3 suspect meta
    11'b0_0_1_1_1_01_1_00_0,  // R1 R3 bad and suspect
    11'b0_0_0_1_0_11_0_00_0,  // R12 undecoded read
    11'b1_1_1_0_0_00_0_00_1,  // R12 persistent write commits
    11'b1_0_1_0_0_00_0_00_0,  // R12 volatile write
    11'b1_1_0_0_0_00_0_00_0   // R12 undecoded write dropped
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_persist = 0; req_decoded = 0;
    req_data_bad = 0; req_meta_suspect = 0; rd_meta = '0;
    fatal_err = 0; viral_in = 0; rst_req = 0; rst_kind = '0;
    sd_req = 0; sd_to_clean = 0; gpf_done = 0;
  endtask

  task automatic issue(input logic wr, input logic pers, input logic dec,
                       input logic bd, input logic sus, input logic [MW-1:0] m,
                       input logic [TW-1:0] tg);
    req_valid = 1; req_write = wr; req_persist = pers; req_decoded = dec;
    req_data_bad = bd; req_meta_suspect = sus; rd_meta = m; req_tag = tg;
    rd_data = 32'hC0DE_0000 | 32'(tg);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_d;
    idle();
    #10;
    chk("R5 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R7 reset viral", 64'(viral_status), 0);
    chk("R11 reset sd_clean", 64'(sd_clean), 0);
    rst_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:4], TW'(i + 3));
      exp_d = VEC[i][10] ? '0 : (VEC[i][8] ? rd_data : '1);
      step();
      chk("R5 rsp_valid", 64'(rsp_valid), 1);
      chk("R5 rsp_write", 64'(rsp_write), 64'(VEC[i][10]));
      chk("R5 rsp_tag", 64'(rsp_tag), 64'(i + 3));
      chk("R12 rsp_data", 64'(rsp_data), 64'(exp_d));
      chk("R1 rsp_poison", 64'(rsp_poison), 64'(VEC[i][3]));
      chk("R3 rsp_meta", 64'(rsp_meta), 64'(VEC[i][2:1]));
      chk("R12 pcommit", 64'(pcommit), 64'(VEC[i][0]));
      idle();
    end
    step();
    chk("R5 idle no rsp", 64'(rsp_valid), 0);

    // R13: bad read alone does not enter viral
    viral_en = 1;
    issue(0, 0, 1, 1, 0, 2'b01, 4'h1);
    step(); idle(); step();
    chk("R13 viral after bad read", 64'(viral_status), 0);

    // R8: enable clear blocks fatal and link viral
    viral_en = 0; fatal_err = 1; viral_in = 1;
    step(); idle(); step();
    chk("R8 viral with enable off", 64'(viral_status), 0);
    issue(0, 0, 1, 1, 0, 2'b10, 4'h2);
    step(); idle();
    chk("R8 poison still applies", 64'(rsp_poison), 1);

    // R6/R7: fatal arrives with a persistent write
    viral_en = 1;
    fatal_err = 1;
    issue(1, 1, 1, 0, 0, 2'b00, 4'h5);
    step(); idle();
    chk("R6 commit same cycle", 64'(pcommit), 1);
    chk("R7 viral_status set", 64'(viral_status), 1);
    chk("R7 viral_out set", 64'(viral_out), 1);

    // R2/R3: bad read in viral
    issue(0, 0, 1, 1, 0, 2'b11, 4'h6);
    step(); idle();
    chk("R2 no poison in viral", 64'(rsp_poison), 0);
    chk("R3 meta noop in viral", 64'(rsp_meta), 0);
    chk("R5 rsp in viral", 64'(rsp_valid), 1);

    // R4: persistent write dropped but completed
    issue(1, 1, 1, 0, 0, 2'b00, 4'h7);
    step(); idle();
    chk("R4 no pcommit in viral", 64'(pcommit), 0);
    chk("R4 completion returned", 64'(rsp_valid), 1);
    chk("R4 completion tag", 64'(rsp_tag), 7);

    // R12 in viral: undecoded read still all ones
    issue(0, 0, 0, 0, 0, 2'b01, 4'h8);
    step(); idle();
    chk("R12 undecoded read ones", 64'(rsp_data), 64'(32'hFFFF_FFFF));

    // R11: shutdown blocked while viral
    sd_req = 1; sd_to_clean = 1;
    step(); idle();
    chk("R11 sd_ack", 64'(sd_ack), 1);
    chk("R11 sd_err in viral", 64'(sd_err), 1);
    chk("R11 sd_clean held", 64'(sd_clean), 0);
    gpf_done = 1;
    step(); idle();
    chk("R11 gpf no clean in viral", 64'(sd_clean), 0);

    // R10: reset types
    rst_req = 1; rst_kind = 2'b01;
    step(); idle();
    chk("R10 link reset keeps viral", 64'(viral_status), 1);
    rst_req = 1; rst_kind = 2'b10;
    step(); idle();
    chk("R10 function reset keeps viral", 64'(viral_status), 1);
    rst_req = 1; rst_kind = 2'b00;
    step(); idle();
    chk("R10 conventional clears viral", 64'(viral_status), 0);
    chk("R10 viral_out cleared", 64'(viral_out), 0);

    // R11 outside viral
    sd_req = 1; sd_to_clean = 1;
    step(); idle();
    chk("R11 sd_err ok", 64'(sd_err), 0);
    chk("R11 clean set", 64'(sd_clean), 1);
    sd_req = 1; sd_to_clean = 0;
    step(); idle();
    chk("R11 dirty set", 64'(sd_clean), 0);
    gpf_done = 1;
    step(); idle();
    chk("R11 gpf cleans", 64'(sd_clean), 1);

    // R9: link viral indication
    viral_in = 1;
    step(); idle();
    chk("R9 link viral sets", 64'(viral_status), 1);
    chk("R9 viral_out", 64'(viral_out), 1);
    step();
    chk("R7 sticky", 64'(viral_status), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule